// File: doc/BRIEF.md
# Write-Cycle Protection Qualifier

This block guards the command register of a flash-style memory against writes it should not take. It samples the active-low chip enable, write enable and output enable pins with a fast internal clock. From these it picks out the bus cycles that are genuine writes. For each one it gives the command logic exactly one single-cycle write strobe.

Several kinds of false write are filtered out. A write is refused while the supply-lockout flag is raised. A write is refused when the pin combination forbids it. A write is refused when the enabling condition is too short to be more than noise. A write is refused when the pins were already in the write state as power-on reset released. The block also raises a force-to-read-mode request toward the command state machine for as long as reset or lockout is active.

All four asynchronous inputs pass through two-flop synchronisers first. Every decision is therefore taken on synchronised samples. The glitch threshold is given in sample-clock cycles by the parameter `GLITCH_CYC`.

Top module: `wr_cycle_gate`

## Requirements
- R1: While the synchronised lockout flag is high, `wr_strobe` stays low. This holds for cycles begun before the lockout and for cycles inside it.
- R2: `force_read` is high while `rst_n` is low. It stays high until the released lockout level has crossed the synchroniser. After that it follows the lockout input, delayed by two clock edges.
- R3: When lockout clears while chip enable and write enable are still low, that cycle is not accepted. A write is accepted again only after chip enable or write enable has been sampled high.
- R4: A write is valid when chip enable is 0, write enable is 0 and output enable is 1 for `GLITCH_CYC` consecutive samples. It ends when write enable or chip enable returns to 1 while output enable is still 1. `wr_strobe` then goes high after the third rising clock edge that follows that pin change.
- R5: If the write condition holds for fewer than `GLITCH_CYC` consecutive samples, no strobe is produced. Exactly `GLITCH_CYC` samples is enough for a strobe.
- R6: Output enable at 0 blocks a write from starting. If output enable falls before the cycle ends, the cycle is dropped with no strobe.
- R7: A valid cycle ended by chip enable rising while write enable is still 0 produces a strobe, just as a write-enable rise does.
- R8: Suppose chip enable and write enable are 0 and output enable is 1 when `rst_n` releases. Then the following write-enable rise produces no strobe. Normal writes resume after that rise.
- R9: `wr_strobe` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| vlow_lock | input | 1 | Low-supply lockout flag, active high, asynchronous |
| wr_strobe | output | 1 | One-cycle pulse per accepted write cycle |
| force_read | output | 1 | Request to hold the command logic in read mode |

## Verification
The qualifier is tried with several write cycles:
- clean cycles closed by write enable, and by chip enable rising first;
- cycles held one sample short of the threshold, and cycles held exactly at it;
- cycles with output enable low from the start, and cycles that output enable cuts off;
- cycles that start, persist or get interrupted under lockout;
- cycles already armed at reset release.

Comparing short against exact-threshold cycles isolates the glitch counter's boundary. The lockout and power-up cases separate the re-arm rule from plain pin gating. Each case is compared every clock against a behavioural model, and the strobes counted in each case are compared with an expected count.

// File: rtl/wr_cycle_gate.sv
module wr_cycle_gate #(
  parameter int GLITCH_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic vlow_lock,
  output logic wr_strobe,
  output logic force_read
);
  localparam int CW = $clog2(GLITCH_CYC + 1);

  logic [3:0] sync1, sync2;
  logic ce_s, we_s, oe_s, lock_s;
  logic [CW-1:0] cnt;
  logic active, blk;
  logic cond, at_thr, end_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
    end else begin
      sync1 <= {vlow_lock, oe_n, we_n, ce_n};
      sync2 <= sync1;
    end

  assign ce_s   = sync2[0];
  assign we_s   = sync2[1];
  assign oe_s   = sync2[2];
  assign lock_s = sync2[3];

  assign cond    = !ce_s && !we_s && oe_s && !lock_s;
  assign at_thr  = cond && (cnt >= CW'(GLITCH_CYC - 1));
  assign end_evt = active && !cond && !lock_s && oe_s && (ce_s || we_s);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      blk       <= 1'b1;
      cnt       <= '0;
      active    <= 1'b0;
      wr_strobe <= 1'b0;
    end else if (lock_s) begin
      blk       <= 1'b1;
      cnt       <= '0;
      active    <= 1'b0;
      wr_strobe <= 1'b0;
    end else begin
      wr_strobe <= end_evt;
      if (blk) begin
        cnt    <= '0;
        active <= 1'b0;
        if (ce_s || we_s) blk <= 1'b0;
      end else if (cond) begin
        if (!at_thr) cnt <= cnt + CW'(1);
        active <= active || at_thr;
      end else begin
        cnt    <= '0;
        active <= 1'b0;
      end
    end

  assign force_read = !rst_n || lock_s;
endmodule

// File: rtl/wr_cycle_gate_chk.sv
module wr_cycle_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_strobe,
  input logic lock_s,
  input logic ce_s,
  input logic we_s,
  input logic oe_s,
  input logic active
);
  p_lock_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_s) |-> !wr_strobe);

  p_end_by_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> ($past(ce_s) || $past(we_s)) && $past(oe_s) && $past(active));

  p_lock_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_s |=> !active);

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);
endmodule

bind wr_cycle_gate wr_cycle_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .lock_s(lock_s),
  .ce_s(ce_s), .we_s(we_s), .oe_s(oe_s), .active(active)
);

// File: tb/sim_wr_cycle_gate.sv
`timescale 1ns/1ps
module sim_wr_cycle_gate;
  localparam int CLK_NS = 10;
  localparam int G = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vlow_lock = 1'b0;
  logic wr_strobe, force_read;

  int n_vec = 0, n_bad = 0, n_stb = 0;
  string cur_req = "R2";
  bit done = 1'b0;

  wr_cycle_gate #(.GLITCH_CYC(G)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .vlow_lock(vlow_lock), .wr_strobe(wr_strobe), .force_read(force_read)
  );

  always #(CLK_NS/2) clk = ~clk;

  // behavioural reference: two-sample delay lines and scalar state
  bit d1_ce = 1, d1_we = 1, d1_oe = 1, d1_lk = 1;
  bit d2_ce = 1, d2_we = 1, d2_oe = 1, d2_lk = 1;
  bit m_blk = 1, m_act = 0, m_stb = 0;
  int m_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      d1_ce = 1; d1_we = 1; d1_oe = 1; d1_lk = 1;
      d2_ce = 1; d2_we = 1; d2_oe = 1; d2_lk = 1;
      m_blk = 1; m_act = 0; m_stb = 0; m_cnt = 0;
    end else begin
      bit c;
      c = !d2_ce && !d2_we && d2_oe && !d2_lk;
      if (d2_lk) begin
        m_blk = 1; m_act = 0; m_stb = 0; m_cnt = 0;
      end else begin
        m_stb = m_act && !c && d2_oe && (d2_ce || d2_we);
        if (m_blk) begin
          m_cnt = 0; m_act = 0;
          if (d2_ce || d2_we) m_blk = 0;
        end else if (c) begin
          m_cnt++;
          if (m_cnt >= G) m_act = 1;
        end else begin
          m_cnt = 0; m_act = 0;
        end
      end
      d2_ce = d1_ce; d2_we = d1_we; d2_oe = d1_oe; d2_lk = d1_lk;
      d1_ce = ce_n;  d1_we = we_n;  d1_oe = oe_n;  d1_lk = vlow_lock;
    end
  end

  bit prev_stb = 0;
  always @(negedge clk) begin
    bit exp_fr, exp_stb;
    exp_fr  = !rst_n || d2_lk;
    exp_stb = rst_n ? m_stb : 1'b0;
    n_vec++;
    if (force_read !== exp_fr) begin
      n_bad++;
      $display("FAIL %s/R2 force_read got %b exp %b at %0t", cur_req, force_read, exp_fr, $time);
    end
    n_vec++;
    if (wr_strobe !== exp_stb) begin
      n_bad++;
      $display("FAIL %s wr_strobe got %b exp %b at %0t", cur_req, wr_strobe, exp_stb, $time);
    end
    if (prev_stb && wr_strobe) begin
      n_bad++;
      $display("FAIL R9 strobe wide got 1 exp 0 at %0t", $time);
    end
    prev_stb = wr_strobe;
    if (wr_strobe === 1'b1) n_stb++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input bit c, input bit w, input bit o);
    ce_n = c; we_n = w; oe_n = o;
  endtask

  task automatic expect_stb(input string req, input int exp);
    n_vec++;
    if (n_stb != exp) begin
      n_bad++;
      $display("FAIL %s strobe count got %0d exp %0d", req, n_stb, exp);
    end
    n_stb = 0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_bad++;
    $display("FAIL watchdog got timeout exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(6);
    expect_stb("R2", 0);

    cur_req = "R4"; // clean cycle ended by write enable
    pins(0, 0, 1); cyc(8); pins(0, 1, 1); cyc(2); pins(1, 1, 1); cyc(6);
    expect_stb("R4", 1);

    cur_req = "R5"; // one sample short
    pins(0, 0, 1); cyc(G - 1); pins(1, 1, 1); cyc(6);
    expect_stb("R5", 0);
    pins(0, 0, 1); cyc(G); pins(1, 1, 1); cyc(6); // exactly at threshold
    expect_stb("R5", 1);

    cur_req = "R6"; // oe low throughout
    pins(0, 0, 0); cyc(8); pins(1, 1, 0); cyc(3); pins(1, 1, 1); cyc(6);
    expect_stb("R6", 0);
    pins(0, 0, 1); cyc(8); pins(0, 0, 0); cyc(3); pins(0, 1, 0); cyc(3); pins(1, 1, 1); cyc(6);
    expect_stb("R6", 0);

    cur_req = "R7"; // chip enable rises first
    pins(0, 0, 1); cyc(8); pins(1, 0, 1); cyc(3); pins(1, 1, 1); cyc(6);
    expect_stb("R7", 1);

    cur_req = "R1"; // write inside lockout
    vlow_lock = 1'b1; cyc(4);
    pins(0, 0, 1); cyc(8); pins(1, 1, 1); cyc(6);
    expect_stb("R1", 0);
    vlow_lock = 1'b0; cyc(6);
    pins(0, 0, 1); cyc(8); vlow_lock = 1'b1; cyc(4); pins(1, 1, 1); cyc(6);
    expect_stb("R1", 0);

    cur_req = "R3"; // cycle spanning the end of lockout
    pins(0, 0, 1); cyc(4); vlow_lock = 1'b0; cyc(12); pins(1, 1, 1); cyc(6);
    expect_stb("R3", 0);
    pins(0, 0, 1); cyc(8); pins(1, 1, 1); cyc(6);
    expect_stb("R3", 1);

    cur_req = "R8"; // armed pins at reset release
    rst_n = 1'b0; pins(0, 0, 1); cyc(4);
    rst_n = 1'b1; cyc(12); pins(0, 1, 1); cyc(3); pins(1, 1, 1); cyc(6);
    expect_stb("R8", 0);
    pins(0, 0, 1); cyc(8); pins(0, 1, 1); cyc(6); pins(1, 1, 1); cyc(4);
    expect_stb("R8", 1);

    cur_req = "R9";
    repeat (3) begin pins(0, 0, 1); cyc(G + 2); pins(1, 1, 1); cyc(5); end
    expect_stb("R9", 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule